// File: doc/BRIEF.md
# NAND Pin Bridge with Self-Timed Strobes

This block sits between a simple single-request host bus and the pins of up to four parallel NAND flash devices that share one I/O bus. Software sets the latch-enable lines, the per-device chip enables, a spare enable and the write-protect line as plain bits in a pin register. It picks an 8-bit or 16-bit bus width in a separate width register. Every access to the data port becomes one bus cycle on the flash side. On a write the bridge drives the shared I/O lines and pulses the write strobe. On a read it pulses the read strobe and returns the sampled I/O value. Software does not drive either strobe.

The bridge does not decode flash commands and does not order operations. It only turns host accesses into correctly timed pin activity. A write-strobe cycle passes through the states ST_IDLE, ST_WR_LOW and ST_WR_HOLD, then back to ST_IDLE. A read-strobe cycle passes through ST_IDLE, ST_RD_LOW and ST_RD_HOLD, then back to ST_IDLE. ST_IDLE moves to ST_WR_LOW on an accepted data-port write and to ST_RD_LOW on an accepted data-port read. Each LOW state moves to its HOLD state after STROBE_CYC clocks. Each HOLD state returns to ST_IDLE after HOLD_CYC clocks and raises the completion pulse as it leaves. Register accesses never leave ST_IDLE.

Top module: `nand_pin_bridge`

## Requirements
- R1: After reset, all four chip enables, the spare enable and write protect are high. CLE and ALE are low. Both strobes are high, no I/O bit is driven, and the width register reads 1 (8-bit mode).
- R2: A write to offset 0x14 loads the pin register. Bit 0 drives CLE, bit 1 drives ALE, bits 5:2 drive chip enables 3..0 (active low, bit 2 is device 0), bit 6 drives the spare enable (active low) and bit 7 drives write protect (active low). The pins change in the cycle after the request is accepted, and a read of 0x14 returns the register in bits 7:0 with zeros above.
- R3: A write to offset 0x10 sets the bus width from bit 0: 1 selects 8-bit mode and 0 selects 16-bit mode. A read of 0x10 returns that bit in bit 0 with zeros above.
- R4: A write to offset 0x00 drives the write data onto the I/O lines. The write strobe goes low for exactly STROBE_CYC clocks, starting in the cycle after acceptance. It then stays high for HOLD_CYC clocks while the data is still driven. The I/O lines are released in the same cycle that host_done pulses, which is STROBE_CYC+HOLD_CYC+1 cycles after the request cycle.
- R5: A read of offset 0x00 holds the read strobe low for exactly STROBE_CYC clocks and samples the I/O input in the last of those clocks. It then holds the strobe high for HOLD_CYC clocks and pulses host_done with the sampled value on host_rdata, STROBE_CYC+HOLD_CYC+1 cycles after the request cycle.
- R6: In 8-bit mode only I/O bits 7:0 are driven, and data-port reads return zero in bits 15:8. In 16-bit mode all 16 bits are driven and returned.
- R7: The write and read strobes are never low together, and the bridge never drives the I/O lines while the read strobe is low.
- R8: A request that arrives while host_busy is high is dropped. It produces no completion pulse and changes no register or pin.
- R9: A read of an unmapped offset returns zero. A write to an unmapped offset changes no pin. Both complete like a register access.
- R10: Register and unmapped accesses complete with a one-cycle host_done pulse in the cycle after the request, with no strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | One-cycle access request, accepted when host_busy is low |
| host_we | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | ADDR_W | Byte offset of the access |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid while host_done is high |
| host_done | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | High while a strobe cycle is in progress |
| nand_cle | output | 1 | Command latch enable, common to all devices |
| nand_ale | output | 1 | Address latch enable, common to all devices |
| nand_ce_n | output | NUM_CE | Active-low chip enables, one per device |
| nand_se_n | output | 1 | Active-low spare enable |
| nand_wp_n | output | 1 | Active-low write protect |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | DATA_W | Value for the shared I/O lines |
| nand_io_oe | output | DATA_W | Per-bit output enable for the I/O lines |
| nand_io_in | input | DATA_W | Value sampled from the shared I/O lines |

## Verification
The assertions assume the host raises host_req for a single cycle with a known address. They also assume the flash side returns read data that holds steady while the read strobe is low. The bench issues every request for one cycle only and waits for host_done before it sends the next one. There is one exception: a deliberate request during host_busy, which exercises the drop rule. The bench models the flash data as a value that appears only while the read strobe is low, so a sample taken in the wrong cycle returns zero rather than the expected word.

// File: rtl/nbr_pkg.sv
package nbr_pkg;

    localparam int NUM_CE    = 4;
    localparam int OFF_DATA  = 'h00;
    localparam int OFF_WIDTH = 'h10;
    localparam int OFF_PINS  = 'h14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LOW,
        ST_WR_HOLD,
        ST_RD_LOW,
        ST_RD_HOLD
    } strobe_st_e;

    // Packed so that the register bit positions match the host view:
    // bit7 wp_n, bit6 se_n, bits5:2 ce_n[3:0], bit1 ale, bit0 cle
    typedef struct packed {
        logic              wp_n;
        logic              se_n;
        logic [NUM_CE-1:0] ce_n;
        logic              ale;
        logic              cle;
    } pin_ctrl_t;

    localparam pin_ctrl_t PIN_CTRL_RST = '{
        wp_n: 1'b1,
        se_n: 1'b1,
        ce_n: {NUM_CE{1'b1}},
        ale:  1'b0,
        cle:  1'b0
    };

endpackage

// File: rtl/nbr_regs.sv
module nbr_regs
    import nbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_pins,
    input  logic       wr_width,
    input  logic [7:0] wdata,
    output pin_ctrl_t  pins_q,
    output logic       x8_mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= PIN_CTRL_RST;
        end else if (wr_pins) begin
            pins_q <= pin_ctrl_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x8_mode_q <= 1'b1;
        end else if (wr_width) begin
            x8_mode_q <= wdata[0];
        end
    end

endmodule

// File: rtl/nbr_strobe_fsm.sv
module nbr_strobe_fsm
    import nbr_pkg::*;
#(
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_rd,
    output logic we_n,
    output logic re_n,
    output logic drive_en,
    output logic sample_en,
    output logic busy,
    output logic done
);

    localparam int MAX_CYC = (STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] LOW_LOAD  = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);

    strobe_st_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             last_cyc;

    assign last_cyc = (cnt_q == '0);

    // State register and phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_wr) begin
                        state_q <= ST_WR_LOW;
                        cnt_q   <= LOW_LOAD;
                    end else if (start_rd) begin
                        state_q <= ST_RD_LOW;
                        cnt_q   <= LOW_LOAD;
                    end
                end
                ST_WR_LOW: begin
                    if (last_cyc) begin
                        state_q <= ST_WR_HOLD;
                        cnt_q   <= HOLD_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_RD_LOW: begin
                    if (last_cyc) begin
                        state_q <= ST_RD_HOLD;
                        cnt_q   <= HOLD_LOAD;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_WR_HOLD, ST_RD_HOLD: begin
                    if (last_cyc) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        we_n      = 1'b1;
        re_n      = 1'b1;
        drive_en  = 1'b0;
        sample_en = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_WR_LOW: begin
                we_n     = 1'b0;
                drive_en = 1'b1;
            end
            ST_WR_HOLD: drive_en = 1'b1;
            ST_RD_LOW: begin
                re_n      = 1'b0;
                sample_en = last_cyc;
            end
            ST_RD_HOLD: ;
            default:    busy = 1'b0;
        endcase
    end

    assign done = done_q;

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));

    // R7
    no_drive_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !drive_en);

    // R4
    data_past_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> drive_en);

    // R4
    done_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/nbr_io_path.sv
module nbr_io_path #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x8_mode,
    input  logic              load_wdata,
    input  logic [DATA_W-1:0] wdata,
    input  logic              drive_en,
    input  logic [DATA_W-1:0] io_in,
    output logic [DATA_W-1:0] io_out,
    output logic [DATA_W-1:0] io_oe,
    output logic [DATA_W-1:0] rd_sample
);

    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] wdata_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            assign lane_en[g] = 1'b1;
        end else begin : g_wide
            assign lane_en[g] = ~x8_mode;
        end
        assign bit_mask[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (load_wdata) begin
            wdata_q <= wdata;
        end
    end

    assign io_out    = wdata_q & bit_mask;
    assign io_oe     = drive_en ? bit_mask : '0;
    assign rd_sample = io_in & bit_mask;

    // R6
    narrow_lanes_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x8_mode |-> (io_oe[DATA_W-1:LANE_W] == '0));

    // R4
    data_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en)) |-> $stable(io_out));

endmodule

// File: rtl/nand_pin_bridge.sv
module nand_pin_bridge
    import nbr_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 16,
    parameter int LANE_W     = 8,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              host_busy,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic [NUM_CE-1:0] nand_ce_n,
    output logic              nand_se_n,
    output logic              nand_wp_n,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_io_out,
    output logic [DATA_W-1:0] nand_io_oe,
    input  logic [DATA_W-1:0] nand_io_in
);

    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_WIDTH = ADDR_W'(OFF_WIDTH);
    localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(OFF_PINS);

    logic              accept;
    logic              hit_data;
    logic              hit_width;
    logic              hit_pins;
    logic              start_wr;
    logic              start_rd;
    logic              drive_en;
    logic              sample_en;
    logic              data_done;
    logic              reg_done_q;
    logic              x8_mode;
    pin_ctrl_t         pins_q;
    logic [DATA_W-1:0] rd_sample;
    logic [DATA_W-1:0] reg_view;
    logic [DATA_W-1:0] rdata_q;

    assign accept    = host_req && !host_busy;
    assign hit_data  = (host_addr == A_DATA);
    assign hit_width = (host_addr == A_WIDTH);
    assign hit_pins  = (host_addr == A_PINS);
    assign start_wr  = accept && hit_data && host_we;
    assign start_rd  = accept && hit_data && !host_we;

    nbr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_pins   (accept && hit_pins && host_we),
        .wr_width  (accept && hit_width && host_we),
        .wdata     (host_wdata[7:0]),
        .pins_q    (pins_q),
        .x8_mode_q (x8_mode)
    );

    nbr_strobe_fsm #(
        .STROBE_CYC (STROBE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_rd  (start_rd),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .drive_en  (drive_en),
        .sample_en (sample_en),
        .busy      (host_busy),
        .done      (data_done)
    );

    nbr_io_path #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .x8_mode    (x8_mode),
        .load_wdata (start_wr),
        .wdata      (host_wdata),
        .drive_en   (drive_en),
        .io_in      (nand_io_in),
        .io_out     (nand_io_out),
        .io_oe      (nand_io_oe),
        .rd_sample  (rd_sample)
    );

    always_comb begin
        reg_view = '0;
        if (hit_pins) begin
            reg_view = DATA_W'(pins_q);
        end else if (hit_width) begin
            reg_view = DATA_W'(x8_mode);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_done_q <= 1'b0;
            rdata_q    <= '0;
        end else begin
            reg_done_q <= accept && !hit_data;
            if (accept && !hit_data && !host_we) begin
                rdata_q <= reg_view;
            end else if (sample_en) begin
                rdata_q <= rd_sample;
            end
        end
    end

    assign host_done  = reg_done_q | data_done;
    assign host_rdata = rdata_q;
    assign nand_cle   = pins_q.cle;
    assign nand_ale   = pins_q.ale;
    assign nand_ce_n  = pins_q.ce_n;
    assign nand_se_n  = pins_q.se_n;
    assign nand_wp_n  = pins_q.wp_n;

    // R8
    pins_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && $past(host_busy)) |-> $stable(pins_q));

    // R10
    reg_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_done_q |-> (nand_we_n && nand_re_n));

    // R8
    no_done_mid_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && $past(host_busy)) |-> !host_done);

endmodule

// File: tb/nand_pin_bridge_bench.sv
`timescale 1ns/1ps
module nand_pin_bridge_bench;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int SCYC   = 3;
    localparam int HCYC   = 2;

    typedef struct {
        bit          chk;
        logic [15:0] exp;
        string       tag;
    } rd_item_t;

    typedef struct {
        logic [15:0] val;
        logic [15:0] oe;
        string       tag;
    } wr_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_req = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] host_rdata;
    logic              host_done;
    logic              host_busy;
    logic              nand_cle, nand_ale, nand_se_n, nand_wp_n;
    logic [3:0]        nand_ce_n;
    logic              nand_we_n, nand_re_n;
    logic [DATA_W-1:0] nand_io_out, nand_io_oe, nand_io_in;
    logic [15:0]       flash_val = 16'h0000;

    int errors = 0;
    int checks = 0;
    int dones  = 0;
    int issued = 0;
    bit drove_in_read = 1'b0;

    rd_item_t rd_q[$];
    wr_item_t wr_q[$];

    always #2 clk = ~clk;

    assign nand_io_in = nand_re_n ? 16'h0000 : flash_val;

    nand_pin_bridge #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(8),
        .STROBE_CYC(SCYC), .HOLD_CYC(HCYC)
    ) u_nand_pin_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .host_busy(host_busy), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_ce_n(nand_ce_n), .nand_se_n(nand_se_n),
        .nand_wp_n(nand_wp_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Result monitor: pops expected read data on every completion
    always @(negedge clk) begin
        if (rst_n && host_done) begin
            dones++;
            if (rd_q.size() == 0) begin
                check("R8 unexpected completion", 32'd1, 32'd0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                if (it.chk) check(it.tag, 32'(host_rdata), 32'(it.exp));
            end
        end
    end

    // Pin monitor: strobe widths, hold time, written value
    int          we_low = 0, re_low = 0, hold_cnt = 0;
    logic        prev_we = 1'b1, prev_re = 1'b1;
    logic [15:0] prev_oe = '0, last_val = '0, last_oe = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_re_n && nand_io_oe != 0) drove_in_read = 1'b1;
            if (!nand_we_n) begin
                we_low++;
                last_val = nand_io_out & nand_io_oe;
                last_oe  = nand_io_oe;
            end
            if (!nand_re_n) re_low++;
            if (nand_we_n && !prev_we) begin
                check("R4 write strobe low width", 32'(we_low), 32'(SCYC));
                we_low = 0;
                if (wr_q.size() == 0) begin
                    check("R4 unexpected write strobe", 32'd1, 32'd0);
                end else begin
                    wr_item_t w;
                    w = wr_q.pop_front();
                    check({w.tag, " value"}, 32'(last_val), 32'(w.val));
                    check({w.tag, " enables"}, 32'(last_oe), 32'(w.oe));
                end
            end
            if (nand_re_n && !prev_re) begin
                check("R5 read strobe low width", 32'(re_low), 32'(SCYC));
                re_low = 0;
            end
            if (nand_we_n && nand_io_oe != 0) hold_cnt++;
            if (nand_io_oe == 0 && prev_oe != 0) begin
                check("R4 data hold after rising strobe", 32'(hold_cnt), 32'(HCYC));
                hold_cnt = 0;
            end
            prev_we = nand_we_n;
            prev_re = nand_re_n;
            prev_oe = nand_io_oe;
        end
    end

    // Driver: one request, expected items pushed, latency checked
    task automatic access(input bit we, input logic [4:0] addr, input logic [15:0] wd,
                          input bit chk, input logic [15:0] exp, input int lat_exp,
                          input string tag);
        rd_item_t it;
        int lat = 0;
        @(negedge clk);
        while (host_busy) @(negedge clk);
        it.chk = chk; it.exp = exp; it.tag = tag;
        rd_q.push_back(it);
        issued++;
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " completion latency"}, 32'(lat), 32'(lat_exp));
    endtask

    task automatic data_write(input logic [15:0] wd, input bit x8, input string tag);
        wr_item_t w;
        w.oe  = x8 ? 16'h00FF : 16'hFFFF;
        w.val = wd & w.oe;
        w.tag = tag;
        wr_q.push_back(w);
        access(1'b1, 5'h00, wd, 1'b0, 16'h0, SCYC + HCYC + 1, tag);
    endtask

    task automatic pins_are(input logic [7:0] exp, input string tag);
        check(tag, 32'({nand_wp_n, nand_se_n, nand_ce_n, nand_ale, nand_cle}), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        pins_are(8'hFC, "R1 pin reset values");
        check("R1 strobes idle high", 32'({nand_we_n, nand_re_n}), 32'h3);
        check("R1 bus not driven", 32'(nand_io_oe), 32'h0);
        rst_n = 1'b1;
        access(1'b0, 5'h10, 16'h0, 1'b1, 16'h0001, 1, "R1 R3 width reset reads 8-bit");

        // R2 pin register, R10 register latency
        access(1'b1, 5'h14, 16'h00F8, 1'b0, 16'h0, 1, "R10 pin write");
        pins_are(8'hF8, "R2 chip 0 selected");
        check("R2 only ce0 low", 32'(nand_ce_n), 32'hE);
        access(1'b1, 5'h14, 16'h00F5, 1'b0, 16'h0, 1, "R10 pin write");
        check("R2 cle from bit0", 32'({nand_cle, nand_ale}), 32'h2);
        check("R2 ce1 selected", 32'(nand_ce_n), 32'hD);
        access(1'b1, 5'h14, 16'hFF3A, 1'b0, 16'h0, 1, "R10 pin write");
        check("R2 ale from bit1, se_n/wp_n low", 32'({nand_wp_n, nand_se_n, nand_ale, nand_cle}), 32'h2);
        access(1'b1, 5'h14, 16'h00FA, 1'b0, 16'h0, 1, "R10 pin write");
        access(1'b0, 5'h14, 16'h0, 1'b1, 16'h00FA, 1, "R2 pin readback");

        // R4 R6 8-bit write and read
        data_write(16'hA55A, 1'b1, "R4 R6 x8 write");
        flash_val = 16'hBEEF;
        access(1'b0, 5'h00, 16'h0, 1'b1, 16'h00EF, SCYC + HCYC + 1, "R5 R6 x8 read");

        // R3 switch to 16-bit
        access(1'b1, 5'h10, 16'h0000, 1'b0, 16'h0, 1, "R3 width write");
        access(1'b0, 5'h10, 16'h0, 1'b1, 16'h0000, 1, "R3 width reads 16-bit");
        data_write(16'h1234, 1'b0, "R4 R6 x16 write");
        flash_val = 16'hC3A5;
        access(1'b0, 5'h00, 16'h0, 1'b1, 16'hC3A5, SCYC + HCYC + 1, "R5 R6 x16 read");
        flash_val = 16'h0F0F;
        access(1'b0, 5'h00, 16'h0, 1'b1, 16'h0F0F, SCYC + HCYC + 1, "R5 second pattern");

        // R8 request during busy is dropped
        begin
            wr_item_t w;
            rd_item_t it;
            w.val = 16'h5678; w.oe = 16'hFFFF; w.tag = "R8 write under test";
            wr_q.push_back(w);
            it.chk = 1'b0; it.exp = 16'h0; it.tag = "R8 write";
            rd_q.push_back(it);
            issued++;
            @(negedge clk);
            host_req = 1'b1; host_we = 1'b1; host_addr = 5'h00; host_wdata = 16'h5678;
            @(negedge clk);
            host_addr = 5'h14; host_wdata = 16'h0000;
            @(negedge clk);
            host_req = 1'b0;
            repeat (SCYC + HCYC + 4) @(negedge clk);
            pins_are(8'hFA, "R8 pins unchanged by dropped request");
            check("R8 completion count", 32'(dones), 32'(issued));
        end

        // R9 unmapped offsets
        access(1'b0, 5'h08, 16'h0, 1'b1, 16'h0000, 1, "R9 unmapped read");
        access(1'b1, 5'h0C, 16'h0000, 1'b0, 16'h0, 1, "R9 unmapped write");
        pins_are(8'hFA, "R9 pins unchanged");

        repeat (4) @(negedge clk);
        check("R7 bus never driven with read strobe low", 32'(drove_in_read), 32'd0);
        check("R4 all writes seen on pins", 32'(wr_q.size()), 32'd0);
        check("R10 all completions seen", 32'(dones), 32'(issued));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule